// File: doc/BRIEF.md
# Polarity-Qualified Sticky Event Flags with Masked Interrupt

This block collects eleven event conditions into sticky flags that a host processor reads and clears over a small register port. Each flag watches one source level; a per-flag polarity bit chooses whether the high or the low level counts as active. Because flags follow levels rather than edges, a flag whose source is still active cannot be cleared: it is set again on the next clock.

A mask register picks which flags drive a single combined interrupt line. The line stays high as long as any selected flag is set. Flag 0 is a wake flag whose source is the OR of three wake lines. The remaining ten flags take one peripheral event line each.

The block also reports the present level of 32 raw event lines through two read-only status words. Writes use a one-cycle strobe, and reads are combinational from the word address.

Top module: `evf_event_flags`

## Requirements
- R1: After a synchronous reset, every flag, polarity bit and mask bit is 0, and `irq_comb_o` is 0.
- R2: A flag is set at the clock edge where its source level matches its polarity bit: a polarity of 0 selects the high level, and a polarity of 1 selects the low level. The set flag can be read from word address 0 after that edge.
- R3: Flag bit 0 takes as its source the OR of `wake_i[2:0]`. Flag bits 10:1 take `evt_i[9:0]`, in that order.
- R4: A set flag stays set after its source goes inactive, until it is cleared.
- R5: A write to word address 0 clears every flag bit written as 0 and leaves every flag bit written as 1 unchanged.
- R6: Writing 1 to a bit of word address 3 clears that flag. Writing 0 there has no effect, and that address reads as zero.
- R7: When a set condition and a clear hit the same flag in the same cycle, the set wins. A flag cleared while its source is active therefore reads as set.
- R8: `irq_comb_o` is 1 exactly when some flag with its mask bit (word address 2) at 1 is set. It changes at the same edge as the flag or mask that causes the change.
- R9: Word address 4 returns `raw_i[15:0]`, and word address 5 returns `raw_i[31:16]`, each in bits 15:0 with bits 31:16 at zero.
- R10: Word address 1 holds the polarity bits and word address 2 holds the mask bits, both in bits 10:0. Bits 31:11 of addresses 0 to 2 read as zero, and addresses 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | One-cycle write strobe |
| addr_i | input | 3 | Word address for both read and write |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Combinational read data for `addr_i` |
| evt_i | input | 10 | Peripheral event levels, sources of flags 10:1 |
| wake_i | input | 3 | Wake event levels, ORed into flag 0 |
| raw_i | input | 32 | Raw event levels shown in the status words |
| irq_comb_o | output | 1 | Registered combined interrupt |

## Verification
The bench goes after set-over-clear in the same cycle. A design that gave the clear priority would drop a flag whose source is still held active. It checks that writing 1 into the flag word keeps the flag; a design that stored the written value would clear a flag on a 1 or set one from software. It checks the inverted polarity encoding across mixed patterns, and the three-way wake OR, where a design using only one wake line would miss events. It also checks that the combined line follows the mask at the same edge as the flags, and that reserved bits and the clear word read as zero.

// File: rtl/evf_pkg.sv
package evf_pkg;
  localparam int FLAG_N  = 11;
  localparam int EVT_N   = FLAG_N - 1;
  localparam int WAKE_N  = 3;
  localparam int DATA_W  = 32;
  localparam int RAW_N   = 32;
  localparam int STAT_W  = RAW_N / 2;
  localparam int ADDR_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_FLAG    = 3'd0,
    A_POL     = 3'd1,
    A_MASK    = 3'd2,
    A_CLR     = 3'd3,
    A_STAT_LO = 3'd4,
    A_STAT_HI = 3'd5
  } evf_addr_e;
endpackage

// File: rtl/evf_flag_bank.sv
module evf_flag_bank #(
  parameter int N = evf_pkg::FLAG_N
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] flag_nxt_o
);
  logic [N-1:0] set_w;
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    // polarity 0 = active high, 1 = active low
    assign set_w[i]      = lvl_i[i] ^ pol_i[i];
    assign flag_nxt_o[i] = set_w[i] | (flag_q[i] & ~clr_i[i]);

    always_ff @(posedge clk_i) begin
      if (rst_i) flag_q[i] <= 1'b0;
      else       flag_q[i] <= flag_nxt_o[i];
    end

    a_r2_set_next: assert property (@(posedge clk_i) disable iff (rst_i)
      set_w[i] |=> flag_q[i]);
    a_r5_clear_next: assert property (@(posedge clk_i) disable iff (rst_i)
      (clr_i[i] && !set_w[i]) |=> !flag_q[i]);
    a_r4_hold: assert property (@(posedge clk_i) disable iff (rst_i)
      (!clr_i[i] && !set_w[i]) |=> (flag_q[i] == $past(flag_q[i])));
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/evf_ctrl_regs.sv
module evf_ctrl_regs
  import evf_pkg::*;
#(
  parameter int N = FLAG_N
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wr_bits_i,
  output logic [N-1:0]      pol_o,
  output logic [N-1:0]      mask_o,
  output logic [N-1:0]      mask_nxt_o,
  output logic [N-1:0]      clr_o
);
  logic [N-1:0] pol_q, mask_q;
  logic wr_flag, wr_pol, wr_mask, wr_clr;

  assign wr_flag = wr_en_i && (addr_i == A_FLAG);
  assign wr_pol  = wr_en_i && (addr_i == A_POL);
  assign wr_mask = wr_en_i && (addr_i == A_MASK);
  assign wr_clr  = wr_en_i && (addr_i == A_CLR);

  // zero written to flag word, or one written to clear word
  always_comb begin
    clr_o = '0;
    if (wr_flag) clr_o = ~wr_bits_i;
    if (wr_clr)  clr_o = wr_bits_i;
  end

  assign mask_nxt_o = wr_mask ? wr_bits_i : mask_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pol_q  <= '0;
      mask_q <= '0;
    end else begin
      if (wr_pol) pol_q <= wr_bits_i;
      mask_q <= mask_nxt_o;
    end
  end

  assign pol_o  = pol_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/evf_read_mux.sv
module evf_read_mux
  import evf_pkg::*;
#(
  parameter int N = FLAG_N
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      flag_i,
  input  logic [N-1:0]      pol_i,
  input  logic [N-1:0]      mask_i,
  input  logic [RAW_N-1:0]  raw_i,
  output logic [DATA_W-1:0] rd_data_o
);
  always_comb begin
    rd_data_o = '0;
    case (addr_i)
      A_FLAG:    rd_data_o[N-1:0]      = flag_i;
      A_POL:     rd_data_o[N-1:0]      = pol_i;
      A_MASK:    rd_data_o[N-1:0]      = mask_i;
      A_STAT_LO: rd_data_o[STAT_W-1:0] = raw_i[STAT_W-1:0];
      A_STAT_HI: rd_data_o[STAT_W-1:0] = raw_i[RAW_N-1:STAT_W];
      default:   rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/evf_event_flags.sv
module evf_event_flags
  import evf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [EVT_N-1:0]  evt_i,
  input  logic [WAKE_N-1:0] wake_i,
  input  logic [RAW_N-1:0]  raw_i,
  output logic              irq_comb_o
);
  logic [FLAG_N-1:0] lvl_w, pol_w, mask_w, mask_nxt_w, clr_w, flag_w, flag_nxt_w;
  logic              comb_q;
  logic              unused_wr_hi;

  assign unused_wr_hi = ^wr_data_i[DATA_W-1:FLAG_N];
  assign lvl_w = {evt_i, |wake_i};

  evf_ctrl_regs #(.N(FLAG_N)) u_regs (
    .clk_i(clk_i), .rst_i(rst_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wr_bits_i(wr_data_i[FLAG_N-1:0]), .pol_o(pol_w), .mask_o(mask_w),
    .mask_nxt_o(mask_nxt_w), .clr_o(clr_w)
  );

  evf_flag_bank #(.N(FLAG_N)) u_flags (
    .clk_i(clk_i), .rst_i(rst_i), .lvl_i(lvl_w), .pol_i(pol_w),
    .clr_i(clr_w), .flag_o(flag_w), .flag_nxt_o(flag_nxt_w)
  );

  evf_read_mux #(.N(FLAG_N)) u_rd (
    .addr_i(addr_i), .flag_i(flag_w), .pol_i(pol_w), .mask_i(mask_w),
    .raw_i(raw_i), .rd_data_o(rd_data_o)
  );

  // registered combine, fed from next-state so it tracks the flag edge
  always_ff @(posedge clk_i) begin
    if (rst_i) comb_q <= 1'b0;
    else       comb_q <= |(flag_nxt_w & mask_nxt_w);
  end
  assign irq_comb_o = comb_q;

  a_r8_comb_tracks: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_comb_o == |(flag_w & mask_w));
  a_r1_reset_clears: assert property (@(posedge clk_i)
    rst_i |=> (flag_w == '0 && mask_w == '0 && pol_w == '0 && !irq_comb_o));
endmodule

// File: tb/evf_event_flags_test.sv
module evf_event_flags_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;
  // {pol[10:0], evt[9:0], wake[2:0], expected flags[10:0]}
  localparam logic [34:0] VEC [NV] = '{
    {11'h000, 10'h000, 3'b000, 11'h000},
    {11'h000, 10'h3FF, 3'b000, 11'h7FE},
    {11'h000, 10'h000, 3'b100, 11'h001},
    {11'h7FF, 10'h000, 3'b000, 11'h7FF},
    {11'h7FF, 10'h3FF, 3'b010, 11'h000},
    {11'h555, 10'h0F0, 3'b000, 11'h4B5},
    {11'h000, 10'h201, 3'b011, 11'h403}
  };

  logic        clk = 0, rst = 1, wr_en = 0;
  logic [2:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [9:0]  evt = 0;
  logic [2:0]  wake = 0;
  logic [31:0] raw = 0;
  logic        irq;
  int checks = 0, fails = 0;

  evf_event_flags uut (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .addr_i(addr),
    .wr_data_i(wdata), .rd_data_o(rdata), .evt_i(evt), .wake_i(wake),
    .raw_i(raw), .irq_comb_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD*50000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(3'd0, d); check("R1 flags", d, 0);
    rd(3'd1, d); check("R1 pol", d, 0);
    rd(3'd2, d); check("R1 mask", d, 0);
    check("R1 irq", {31'd0, irq}, 0);

    // table walk: R2 polarity, R3 wake OR and event mapping
    for (int k = 0; k < NV; k++) begin
      logic [10:0] p;
      p = VEC[k][34:24];
      @(negedge clk);
      evt = p[10:1]; wake = p[0] ? 3'b001 : 3'b000;
      wr(3'd1, {21'd0, p});
      wr(3'd3, 32'h7FF);
      rd(3'd0, d); check("R2 idle before vector", d, 0);
      evt = VEC[k][23:14]; wake = VEC[k][13:11];
      @(negedge clk);
      rd(3'd0, d); check("R2/R3 vector flags", d, {21'd0, VEC[k][10:0]});
    end

    // back to pol 0, quiet sources, clear
    evt = 0; wake = 0;
    wr(3'd1, 0); wr(3'd3, 32'h7FF);
    rd(3'd0, d); check("R6 clear all", d, 0);

    // R4 sticky after one-cycle pulse on evt[2] -> flag bit 3
    @(negedge clk); evt = 10'h004;
    @(negedge clk); evt = 0;
    repeat (3) @(negedge clk);
    rd(3'd0, d); check("R4 sticky", d, 32'h008);

    // R5 write one keeps, write zero clears
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, d); check("R5 write one keeps", d, 32'h008);
    wr(3'd0, 32'h7F7);
    rd(3'd0, d); check("R5 write zero clears", d, 0);

    // R6 clear word
    @(negedge clk); evt = 10'h004;
    @(negedge clk); evt = 0;
    wr(3'd3, 0);
    rd(3'd0, d); check("R6 clr zero no effect", d, 32'h008);
    rd(3'd3, d); check("R6 clr reads zero", d, 0);
    wr(3'd3, 32'h008);
    rd(3'd0, d); check("R6 clr one clears", d, 0);

    // R7 set beats clear while source held active
    @(negedge clk); evt = 10'h004;
    wr(3'd3, 32'h008);
    rd(3'd0, d); check("R7 set beats clr word", d, 32'h008);
    wr(3'd0, 0);
    rd(3'd0, d); check("R7 set beats write zero", d, 32'h008);
    evt = 0;
    wr(3'd3, 32'h7FF);
    rd(3'd0, d); check("R7 clears once inactive", d, 0);

    // R8 combined output
    wr(3'd2, 32'h008);
    check("R8 no flag irq low", {31'd0, irq}, 0);
    @(negedge clk); evt = 10'h004;
    @(negedge clk); evt = 0;
    check("R8 masked flag irq high", {31'd0, irq}, 1);
    wr(3'd2, 32'h010);
    check("R8 other mask irq low", {31'd0, irq}, 0);
    wr(3'd2, 32'h008);
    check("R8 mask back irq high", {31'd0, irq}, 1);
    wr(3'd3, 32'h008);
    check("R8 cleared irq low", {31'd0, irq}, 0);

    // R9 status words
    raw = 32'hA5C3_1E96;
    rd(3'd4, d); check("R9 status low", d, 32'h0000_1E96);
    rd(3'd5, d); check("R9 status high", d, 32'h0000_A5C3);

    // R10 reserved bits and unused addresses
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, d); check("R10 mask width", d, 32'h7FF);
    evt = 10'h3FF; wake = 3'b001;
    wr(3'd1, 32'hFFFF_F800);
    rd(3'd1, d); check("R10 pol reserved zero", d, 0);
    rd(3'd6, d); check("R10 addr6 zero", d, 0);
    rd(3'd7, d); check("R10 addr7 zero", d, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule